// File: doc/BRIEF.md
# Memory-Mapped Control/Status Register Slave

This block is a small register bank reached over a 32-bit AXI4-Lite slave port. Software writes configuration through single-beat writes (address, data with byte strobes, then a write response) and reads registers back through single-beat reads. The bank holds a control word, a read-only status word and a general data word. Every other offset inside its address window is reserved.

Access policy is checked on every transaction. Legal accesses answer OKAY. A write to the read-only status word, or any access to a reserved offset, answers SLVERR and changes nothing. An address that falls outside the window answers DECERR. Writing 1 to the start bit of the control word launches a fixed-length internal operation. While it runs a busy flag is set, and when it ends a done flag is set, which software polls.

Only one write and one read are in flight at a time. The address-accept and data-accept signals of a channel drop while that channel's response is waiting.

Top module: `csr_lite_slave`

## Requirements
- R1: Write address and write data are accepted independently, in either order or in the same cycle. No register changes and BVALID stays low until both are taken. BVALID rises on the second clock edge after the later of the two handshakes.
- R2: Each write yields exactly one B response. BVALID and BRESP hold steady until BREADY is high, and BRESP is 2'b00 (OKAY) for a legal write.
- R3: An AR handshake is followed one edge later by RVALID with RDATA and RRESP. These hold steady until RREADY is high.
- R4: Address bits [15:8] equal to zero select the 256-byte window. Inside it, the word at byte offset 0x00 is control, 0x04 is status and 0x08 is data. Address bits [1:0] are ignored.
- R5: On a legal write, each WSTRB bit n set replaces byte lane n (bits 8n+7:8n) and each clear bit keeps the old byte.
- R6: A write to status, or a read or write of a reserved offset (0x0C to 0xFC), returns 2'b10 (SLVERR) and leaves every register unchanged. A reserved read returns data 0.
- R7: Any access with address bits [15:8] nonzero returns 2'b11 (DECERR), changes no register and reads data 0.
- R8: Control bits [31:1] are read/write storage. Bit 0 is the start bit: writing it as 1 with WSTRB[0] set launches the operation, and it always reads 0.
- R9: Status bit 1 (busy) is 1 from the launch edge. Status bit 0 (done) becomes 1, and busy returns to 0, exactly 8 clock edges after the edge that commits the start write.
- R10: A new start clears done at its launch edge.
- R11: After active-low reset, control, status and data read 0, BVALID and RVALID are low, and AWREADY, WREADY and ARREADY are high.
- R12: AWREADY and WREADY are low while BVALID is high, and ARREADY is low while RVALID is high. A channel whose beat is already held also keeps its ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 16 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accept |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte-lane write strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accept |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accept |
| s_araddr | input | 16 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accept |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accept |

## Verification
The bench sends address before data and data before address. A design that commits on the first handshake would answer early or write a stale word into the register. It writes with a partial strobe, to the read-only word, to a reserved hole and outside the window, then reads each target back, so that a strobe mixup, or an error path that still writes, shows up as corrupted data. It polls status on the edge just before and the edge just after completion, and across a second start. An off-by-one timer, a done flag that does not clear, or a start bit that reads back as 1 each gives a wrong status or control value. It also stalls BREADY and RREADY, so a response that drops early, or a ready that reopens while a response is pending, is caught.

// File: rtl/csr_lite_pkg.sv
`timescale 1ns/1ps
package csr_lite_pkg;
  localparam int unsigned CSR_DW = 32;
  localparam int unsigned CSR_SW = CSR_DW / 8;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [2:0] {
    SLOT_CTRL,
    SLOT_STAT,
    SLOT_DATA,
    SLOT_RSVD,
    SLOT_OUTSIDE
  } slot_e;

  // byte-lane merge: strobed lanes take the new byte, the rest keep the old
  function automatic logic [CSR_DW-1:0] lane_merge(
    input logic [CSR_DW-1:0] old_v,
    input logic [CSR_DW-1:0] new_v,
    input logic [CSR_SW-1:0] strb
  );
    logic [CSR_DW-1:0] res;
    for (int i = 0; i < CSR_SW; i++) begin
      res[8*i +: 8] = strb[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/csr_wr_front.sv
`timescale 1ns/1ps
module csr_wr_front
  import csr_lite_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [CSR_DW-1:0] wdata,
  input  logic [CSR_SW-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [CSR_DW-1:0] cm_data,
  output logic [CSR_SW-1:0] cm_strb,
  input  logic [1:0]        cm_resp
);
  logic aw_held, w_held, bvalid_q;
  logic [1:0] bresp_q;
  logic aw_take, w_take;

  assign awready = !aw_held && !bvalid_q;
  assign wready  = !w_held && !bvalid_q;
  assign aw_take = awvalid && awready;
  assign w_take  = wvalid && wready;
  assign commit  = aw_held && w_held;
  assign bvalid  = bvalid_q;
  assign bresp   = bresp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OKAY;
      cm_addr  <= '0;
      cm_data  <= '0;
      cm_strb  <= '0;
    end else begin
      if (commit) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
        bresp_q  <= cm_resp;
      end else begin
        if (aw_take) begin
          aw_held <= 1'b1;
          cm_addr <= awaddr;
        end
        if (w_take) begin
          w_held  <= 1'b1;
          cm_data <= wdata;
          cm_strb <= wstrb;
        end
        if (bvalid_q && bready) bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csr_rd_front.sv
`timescale 1ns/1ps
module csr_rd_front
  import csr_lite_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [CSR_DW-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              rd_take,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [CSR_DW-1:0] rd_data,
  input  logic [1:0]        rd_resp
);
  logic rvalid_q;

  assign arready = !rvalid_q;
  assign rd_take = arvalid && arready;
  assign rd_addr = araddr;
  assign rvalid  = rvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata    <= '0;
      rresp    <= RESP_OKAY;
    end else if (rd_take) begin
      rvalid_q <= 1'b1;
      rdata    <= rd_data;
      rresp    <= rd_resp;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/csr_regbank.sv
`timescale 1ns/1ps
module csr_regbank
  import csr_lite_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BITS  = 8,
  parameter int unsigned OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CSR_DW-1:0] wr_data,
  input  logic [CSR_SW-1:0] wr_strb,
  output logic [1:0]        wr_resp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CSR_DW-1:0] rd_data,
  output logic [1:0]        rd_resp,
  output logic              op_launch,
  output logic              op_finish,
  output logic              busy,
  output logic              done
);
  localparam int unsigned WORD_W = WIN_BITS - 2;
  localparam int unsigned CNT_W  = $clog2(OP_CYCLES + 1);

  function automatic slot_e slot_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:WIN_BITS] != '0) return SLOT_OUTSIDE;
    case (a[WIN_BITS-1:2])
      WORD_W'(0): return SLOT_CTRL;
      WORD_W'(1): return SLOT_STAT;
      WORD_W'(2): return SLOT_DATA;
      default:    return SLOT_RSVD;
    endcase
  endfunction

  function automatic logic [1:0] wr_policy(input slot_e s);
    case (s)
      SLOT_CTRL, SLOT_DATA: return RESP_OKAY;
      SLOT_OUTSIDE:         return RESP_DECERR;
      default:              return RESP_SLVERR;
    endcase
  endfunction

  logic [CSR_DW-1:0] ctrl_q, data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;
  slot_e             wr_slot, rd_slot;
  logic              wr_ok;

  assign wr_slot   = slot_of(wr_addr);
  assign rd_slot   = slot_of(rd_addr);
  assign wr_resp   = wr_policy(wr_slot);
  assign wr_ok     = wr_en && (wr_resp == RESP_OKAY);
  assign op_launch = wr_ok && (wr_slot == SLOT_CTRL) && wr_strb[0] && wr_data[0];
  assign op_finish = busy_q && (cnt_q == CNT_W'(1));
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_ok && wr_slot == SLOT_CTRL)
        ctrl_q <= lane_merge(ctrl_q, wr_data, wr_strb) & ~CSR_DW'(1);
      if (wr_ok && wr_slot == SLOT_DATA)
        data_q <= lane_merge(data_q, wr_data, wr_strb);
      if (op_launch) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= CNT_W'(OP_CYCLES);
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (op_finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_resp = RESP_OKAY;
    case (rd_slot)
      SLOT_CTRL:    rd_data = ctrl_q;
      SLOT_STAT:    rd_data = {{(CSR_DW-2){1'b0}}, busy_q, done_q};
      SLOT_DATA:    rd_data = data_q;
      SLOT_OUTSIDE: rd_resp = RESP_DECERR;
      default:      rd_resp = RESP_SLVERR;
    endcase
  end
endmodule

// File: rtl/csr_lite_slave.sv
`timescale 1ns/1ps
module csr_lite_slave
  import csr_lite_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BITS  = 8,
  parameter int unsigned OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);
  // named internal events, visible to the bound checker
  logic              wr_commit, rd_take, op_launch, op_finish, op_busy, op_done;
  logic [ADDR_W-1:0] cm_addr, rd_addr;
  logic [CSR_DW-1:0] cm_data, rd_data;
  logic [CSR_SW-1:0] cm_strb;
  logic [1:0]        cm_resp, rd_resp;
  logic              wr_err;

  assign wr_err = wr_commit && (cm_resp != RESP_OKAY);

  csr_wr_front #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .commit(wr_commit), .cm_addr(cm_addr), .cm_data(cm_data),
    .cm_strb(cm_strb), .cm_resp(cm_resp)
  );

  csr_rd_front #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_take(rd_take), .rd_addr(rd_addr), .rd_data(rd_data), .rd_resp(rd_resp)
  );

  csr_regbank #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .OP_CYCLES(OP_CYCLES)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_commit), .wr_addr(cm_addr), .wr_data(cm_data), .wr_strb(cm_strb),
    .wr_resp(cm_resp),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_resp(rd_resp),
    .op_launch(op_launch), .op_finish(op_finish), .busy(op_busy), .done(op_done)
  );
endmodule

// File: rtl/csr_lite_checker.sv
`timescale 1ns/1ps
module csr_lite_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        s_awvalid,
  input logic        s_awready,
  input logic        s_wvalid,
  input logic        s_wready,
  input logic        s_bvalid,
  input logic        s_bready,
  input logic [1:0]  s_bresp,
  input logic        s_arready,
  input logic        s_rvalid,
  input logic        s_rready,
  input logic [31:0] s_rdata,
  input logic [1:0]  s_rresp,
  input logic        wr_commit,
  input logic        wr_err,
  input logic        op_launch,
  input logic        op_finish,
  input logic        op_busy,
  input logic        op_done,
  input logic [31:0] ctrl_q,
  input logic [31:0] data_q
);
  logic aw_seen, w_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_seen <= 1'b0;
      w_seen  <= 1'b0;
    end else if (wr_commit) begin
      aw_seen <= 1'b0;
      w_seen  <= 1'b0;
    end else begin
      if (s_awvalid && s_awready) aw_seen <= 1'b1;
      if (s_wvalid && s_wready)   w_seen  <= 1'b1;
    end
  end

  assert_commit_after_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (aw_seen && w_seen));
  assert_resp_follows_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> s_bvalid);
  assert_b_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
  assert_r_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));
  assert_err_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> ($stable(ctrl_q) && $stable(data_q)));
  assert_finish_sets_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_finish |=> (op_done && !op_busy));
  assert_launch_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_launch |=> (op_busy && !op_done));
  assert_w_ready_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> (!s_awready && !s_wready));
  assert_r_ready_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
endmodule

bind csr_lite_slave csr_lite_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wvalid(s_wvalid), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_arready(s_arready), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_rdata(s_rdata), .s_rresp(s_rresp),
  .wr_commit(wr_commit), .wr_err(wr_err),
  .op_launch(op_launch), .op_finish(op_finish),
  .op_busy(op_busy), .op_done(op_done),
  .ctrl_q(u_bank.ctrl_q), .data_q(u_bank.data_q)
);

// File: tb/csr_lite_slave_tb_top.sv
`timescale 1ns/1ps
module csr_lite_slave_tb_top;
  localparam logic [1:0] OK  = 2'b00;
  localparam logic [1:0] SLV = 2'b10;
  localparam logic [1:0] DEC = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
  logic        s_bready = 1, s_rready = 1;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;

  csr_lite_slave dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  typedef struct {
    logic [31:0] data;
    logic [1:0]  resp;
    string       tag;
  } exp_t;

  exp_t bq[$];
  exp_t rq[$];
  exp_t be, re;
  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each response beat as it is handed over
  always @(negedge clk) begin
    if (rst_n) begin
      if (s_bvalid && s_bready) begin
        if (bq.size() == 0) chk(1'b0, "R2 unexpected B beat", 64'(s_bresp), 64'hx);
        else begin
          be = bq.pop_front();
          chk(s_bresp == be.resp, be.tag, 64'(s_bresp), 64'(be.resp));
        end
      end
      if (s_rvalid && s_rready) begin
        if (rq.size() == 0) chk(1'b0, "R3 unexpected R beat", 64'(s_rdata), 64'hx);
        else begin
          re = rq.pop_front();
          chk(s_rdata == re.data && s_rresp == re.resp, re.tag,
              {30'b0, s_rresp, s_rdata}, {30'b0, re.resp, re.data});
        end
      end
    end
  end

  task automatic send_aw(input logic [15:0] a);
    s_awaddr = a;
    s_awvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk);
    s_awvalid = 1'b0;
  endtask

  task automatic send_w();
    s_wvalid = 1'b1;
    while (!s_wready) @(negedge clk);
    @(negedge clk);
    s_wvalid = 1'b0;
  endtask

  // order 0: together, 1: address first, 2: data first
  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] strb,
                    input logic [1:0] resp, input string tag, input int order);
    bq.push_back('{32'h0, resp, tag});
    s_wdata = d;
    s_wstrb = strb;
    if (order == 0) begin
      fork
        send_aw(a);
        send_w();
      join
    end else if (order == 1) begin
      send_aw(a);
      repeat (3) @(negedge clk);
      chk(!s_bvalid && !s_awready, "R1 no response before data (R12 awready low)",
          {62'b0, s_bvalid, s_awready}, 64'h0);
      send_w();
      chk(!s_bvalid, "R1 response not yet one cycle after data", 64'(s_bvalid), 64'h0);
      @(negedge clk);
      chk(s_bvalid, "R1 response two edges after data", 64'(s_bvalid), 64'h1);
    end else begin
      send_w();
      repeat (2) @(negedge clk);
      chk(!s_bvalid && !s_wready, "R1 no response before address (R12 wready low)",
          {62'b0, s_bvalid, s_wready}, 64'h0);
      send_aw(a);
    end
    while (!s_bvalid) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] d, input logic [1:0] resp,
                    input string tag);
    rq.push_back('{d, resp, tag});
    s_araddr = a;
    s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    while (!s_rvalid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (bq.size() != 0 || rq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!s_bvalid && !s_rvalid && s_awready && s_wready && s_arready, "R11 port reset state",
        {59'b0, s_bvalid, s_rvalid, s_awready, s_wready, s_arready}, 64'h7);
    rd(16'h0000, 32'h0, OK, "R11 control resets to 0");
    rd(16'h0004, 32'h0, OK, "R11 status resets to 0");
    rd(16'h0008, 32'h0, OK, "R11 data resets to 0");
    wait_idle();

    // R4 R5 full write and readback, both channels together
    wr(16'h0008, 32'hABCD1234, 4'hF, OK, "R2 okay on data write", 0);
    wait_idle();
    rd(16'h0008, 32'hABCD1234, OK, "R4 data readback");
    wait_idle();
    // R1 address first, then data first
    wr(16'h0008, 32'h11223344, 4'hF, OK, "R1 address-first write", 1);
    wait_idle();
    rd(16'h0008, 32'h11223344, OK, "R1 address-first value landed");
    wait_idle();
    wr(16'h0008, 32'h55667788, 4'hF, OK, "R1 data-first write", 2);
    wait_idle();
    rd(16'h0008, 32'h55667788, OK, "R1 data-first value landed");
    wait_idle();
    // R5 partial strobes: lanes 0 and 2
    wr(16'h0008, 32'hAAAAAAAA, 4'b0101, OK, "R5 strobed write okay", 0);
    wait_idle();
    rd(16'h0008, 32'h55AA77AA, OK, "R5 only strobed lanes changed");
    // R4 low address bits ignored
    rd(16'h000B, 32'h55AA77AA, OK, "R4 bits 1:0 ignored");
    wait_idle();

    // R6 read-only and reserved
    wr(16'h0004, 32'hFFFFFFFF, 4'hF, SLV, "R6 status write slverr", 0);
    wait_idle();
    rd(16'h0004, 32'h0, OK, "R6 status unchanged");
    wr(16'h000C, 32'h12345678, 4'hF, SLV, "R6 reserved write slverr", 0);
    wait_idle();
    rd(16'h00FC, 32'h0, SLV, "R6 reserved read slverr");
    rd(16'h0008, 32'h55AA77AA, OK, "R6 data untouched by error writes");
    wait_idle();
    // R7 outside window
    wr(16'h0108, 32'h0, 4'hF, DEC, "R7 outside write decerr", 0);
    wait_idle();
    rd(16'h0100, 32'h0, DEC, "R7 outside read decerr");
    rd(16'h0008, 32'h55AA77AA, OK, "R7 data untouched by outside write");
    wait_idle();

    // R8 control storage without start
    wr(16'h0000, 32'h000000F0, 4'hF, OK, "R8 control write", 0);
    wait_idle();
    rd(16'h0000, 32'h000000F0, OK, "R8 control readback");
    rd(16'h0004, 32'h0, OK, "R8 no launch without start bit");
    wait_idle();
    // R8 start bit with lane 0 clear does nothing
    wr(16'h0000, 32'h000000F1, 4'b1110, OK, "R8 start with lane0 unstrobed", 0);
    wait_idle();
    rd(16'h0004, 32'h0, OK, "R8 unstrobed start ignored");
    wait_idle();

    // R9 first start: poll on the edge before completion
    wr(16'h0000, 32'h000000F1, 4'hF, OK, "R8 start write okay", 0);
    repeat (7) @(negedge clk);
    rd(16'h0004, 32'h2, OK, "R9 still busy at edge 8");
    rd(16'h0000, 32'h000000F0, OK, "R8 start bit reads 0");
    repeat (4) @(negedge clk);
    rd(16'h0004, 32'h1, OK, "R9 done after completion");
    wait_idle();
    // R10 second start clears done, R9 done visible right after edge 8
    wr(16'h0000, 32'h000000F1, 4'hF, OK, "R10 restart write", 0);
    rd(16'h0004, 32'h2, OK, "R10 done cleared by new start");
    repeat (6) @(negedge clk);
    rd(16'h0004, 32'h1, OK, "R9 done on edge after completion");
    wait_idle();

    // R2 R12 held response with BREADY low
    s_bready = 1'b0;
    wr(16'h0008, 32'h5A5A5A5A, 4'hF, OK, "R2 stalled write okay", 0);
    repeat (4) @(negedge clk);
    chk(s_bvalid && s_bresp == OK, "R2 response held while stalled",
        {61'b0, s_bvalid, s_bresp}, 64'h4);
    chk(!s_awready && !s_wready, "R12 readies low while response pending",
        {62'b0, s_awready, s_wready}, 64'h0);
    s_bready = 1'b1;
    wait_idle();
    // R3 R12 held read beat with RREADY low
    s_rready = 1'b0;
    rd(16'h0008, 32'h5A5A5A5A, OK, "R3 stalled read beat");
    repeat (3) @(negedge clk);
    chk(s_rvalid && s_rdata == 32'h5A5A5A5A, "R3 read beat held while stalled",
        {31'b0, s_rvalid, s_rdata}, {31'b0, 1'b1, 32'h5A5A5A5A});
    chk(!s_arready, "R12 arready low while read pending", 64'(s_arready), 64'h0);
    s_rready = 1'b1;
    wait_idle();

    finish_run();
  end
endmodule